// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel controlled through four 32-bit registers. Software writes a source address, a destination address and a count of transfer units. It then writes the control register to set the enable bit and the interrupt-enable bit and to clear the end flag. The channel then copies the data one unit at a time. Each unit is a read at the source address followed by a write at the destination address. Both accesses go over a simple request/grant memory port. A size index in the control register sets the unit width to 1, 2 or 4 bytes.

After each unit the count drops by one. Each address either advances by the unit width or stays fixed, as its own increment bit selects. When the count reaches zero the channel raises its end flag. The interrupt line is high whenever the end flag and the interrupt-enable bit are both set. Software can halt the channel at any time and then read the live count and addresses to see how far it got. A later start resumes from that point.

Top module: `dma_chan_engine`

## Requirements
- R1: Registers are selected by reg_addr[3:2]: 0 source address, 1 destination address, 2 unit count, 3 control. A write is accepted only when reg_addr[1:0] is 0. reg_rdata shows, one clock after the address is presented, the register selected by reg_addr[3:2]. Control bits: 0 enable, 1 end flag, 2 interrupt enable, 6:4 size index, 8 source increment, 9 destination increment. All other bits read 0.
- R2: After reset the addresses and the count are 0 and the control register reads 0x320: both increments set, size index 2, enable, end flag and interrupt enable clear. mem_req and irq are low.
- R3: Size index 0 selects 1-byte units, 1 selects 2 bytes and 2 selects 4 bytes. Indices 3 to 7 behave as index 0. mem_size gives log2 of the unit width in bytes.
- R4: The channel is busy when enable is 1 and the end flag is 0. While it is busy, writes to the source, destination and count registers have no effect, and neither do writes to the size and increment bits. The enable, end-flag and interrupt-enable bits can still be written.
- R5: Each unit starts with a read request at the source address (mem_we 0), held until it is granted. A write request at the destination address (mem_we 1) follows, also held until granted. Its data is the granted read data with the bytes above the unit width forced to 0.
- R6: Each write grant decrements the count by 1. It advances each address whose increment bit is set by the unit width, and leaves the other address unchanged. At the end the moving address equals its start value plus count times unit width.
- R7: When the channel is busy, between units, with a count of 0, it sets the end flag and makes no further requests. A start with a count of 0 ends without any memory request.
- R8: Writing 0 to the end-flag bit clears it. Writing 1 leaves it unchanged. One control write can set enable and interrupt enable and clear the end flag, which starts the channel.
- R9: A control write with enable 0 halts the channel: from the second cycle after the write, no request is issued. The count and addresses keep the progress made so far, so that remaining units equal programmed units minus units written. A new start continues from that point.
- R10: irq is high exactly while the end flag and the interrupt-enable bit are both set. It stays high until software clears one of them.
- R11: The count register keeps only the low 24 bits of a write, so the largest count is 16M-1 units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 3 | log2 of the access width in bytes |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_gnt | input | 1 | Grant; the access completes in the cycle it is high |
| mem_rdata | input | 32 | Read data, valid with the grant |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Some properties are checked on every cycle. A request that is not granted must keep its address and direction. A granted read is followed by a write or by a drop of the request. Each write grant lowers the count by exactly one. The end flag only rises with a count of zero, and mem_size stays within the size table. A held interrupt does not fall without a control write, and a count write made while busy changes nothing.

Other behaviours can only be shown by the bench's scenarios, which compare the port against a cycle model under constant, stalled and irregular grants. These cover the final address values for fixed and moving addresses, the treatment of out-of-range size indices and the masked write data. They also cover partial progress after a halt, a resume from that point, and a start with a count of zero.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int SZ_W = 3;

  localparam int CTL_EN      = 0;
  localparam int CTL_END     = 1;
  localparam int CTL_IRQEN   = 2;
  localparam int CTL_SZ_LO   = 4;
  localparam int CTL_SRC_INC = 8;
  localparam int CTL_DST_INC = 9;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  // Size index to log2(bytes); indices past the table fall back to entry 0.
  function automatic logic [SZ_W-1:0] unit_shift(input logic [SZ_W-1:0] idx,
                                                 input int unsigned nsz);
    return (32'(idx) < nsz) ? idx : '0;
  endfunction
endpackage

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REG_W    = 32,
  parameter int CNT_W    = 24,
  parameter int NSZ      = 3,
  parameter int DEF_SIZE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              unit_step,
  input  logic              finish,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  unit_cnt,
  output logic [SZ_W-1:0]   shift,
  output logic              busy,
  output logic              end_flag,
  output logic              irq_en
);
  logic              en_q, end_q, ie_q, sinc_q, dinc_q;
  logic [SZ_W-1:0]   szi_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ubytes;
  logic [REG_W-1:0]  ctl_word, rd_mux;
  logic              wr_ok, ctl_wr;
  logic [1:0]        sel;

  assign sel    = reg_addr[3:2];
  assign wr_ok  = reg_we & (reg_addr[1:0] == 2'b00);
  assign ctl_wr = wr_ok & (sel == SEL_CTL);
  assign busy   = en_q & ~end_q;
  assign shift  = unit_shift(szi_q, NSZ);
  assign ubytes = ADDR_W'(1) << shift;

  always_comb begin
    ctl_word                      = '0;
    ctl_word[CTL_EN]              = en_q;
    ctl_word[CTL_END]             = end_q;
    ctl_word[CTL_IRQEN]           = ie_q;
    ctl_word[CTL_SZ_LO +: SZ_W]   = szi_q;
    ctl_word[CTL_SRC_INC]         = sinc_q;
    ctl_word[CTL_DST_INC]         = dinc_q;
  end

  always_comb begin
    case (sel)
      SEL_SRC: rd_mux = REG_W'(src_q);
      SEL_DST: rd_mux = REG_W'(dst_q);
      SEL_CNT: rd_mux = REG_W'(cnt_q);
      default: rd_mux = ctl_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      en_q      <= 1'b0;
      end_q     <= 1'b0;
      ie_q      <= 1'b0;
      sinc_q    <= 1'b1;
      dinc_q    <= 1'b1;
      szi_q     <= SZ_W'(DEF_SIZE);
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
      if (unit_step) begin
        if (sinc_q) src_q <= src_q + ubytes;
        if (dinc_q) dst_q <= dst_q + ubytes;
        cnt_q <= cnt_q - 1'b1;
      end
      if (wr_ok && !busy) begin
        case (sel)
          SEL_SRC: src_q <= reg_wdata[ADDR_W-1:0];
          SEL_DST: dst_q <= reg_wdata[ADDR_W-1:0];
          SEL_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (ctl_wr) begin
        en_q <= reg_wdata[CTL_EN];
        ie_q <= reg_wdata[CTL_IRQEN];
        if (!reg_wdata[CTL_END]) end_q <= 1'b0;
        if (!busy) begin
          szi_q  <= reg_wdata[CTL_SZ_LO +: SZ_W];
          sinc_q <= reg_wdata[CTL_SRC_INC];
          dinc_q <= reg_wdata[CTL_DST_INC];
        end
      end else if (finish) begin
        end_q <= 1'b1;
      end
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign unit_cnt = cnt_q;
  assign end_flag = end_q;
  assign irq_en   = ie_q;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              cnt_zero,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [SZ_W-1:0]   shift,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SZ_W-1:0]   mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              unit_step,
  output logic              finish
);
  localparam int NB = DATA_W / 8;

  phase_t            ph_q;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] keep;
  logic              active;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign keep[b*8 +: 8] = {8{(b >> shift) == 0}};
  end

  assign active    = (ph_q != PH_IDLE) & busy;
  assign mem_req   = active;
  assign mem_we    = (ph_q == PH_WRITE);
  assign mem_addr  = (ph_q == PH_WRITE) ? dst_addr : src_addr;
  assign mem_size  = shift;
  assign mem_wdata = buf_q;
  assign unit_step = active & (ph_q == PH_WRITE) & mem_gnt;
  assign finish    = (ph_q == PH_IDLE) & busy & cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      buf_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE:  if (busy && !cnt_zero) ph_q <= PH_READ;
        PH_READ: begin
          if (!busy) ph_q <= PH_IDLE;
          else if (mem_gnt) begin
            buf_q <= mem_rdata & keep;
            ph_q  <= PH_WRITE;
          end
        end
        PH_WRITE: begin
          if (!busy || mem_gnt) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dmac_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int DEF_SIZE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SZ_W-1:0]   mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  localparam int REG_W = 32;
  localparam int NSZ   = $clog2(DATA_W / 8) + 1;

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [CNT_W-1:0]  unit_cnt;
  logic [SZ_W-1:0]   shift;
  logic              chan_busy, end_flag, irq_en, unit_step, finish;

  dmac_regfile #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W),
    .NSZ(NSZ), .DEF_SIZE(DEF_SIZE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .unit_step(unit_step), .finish(finish),
    .src_addr(src_addr), .dst_addr(dst_addr), .unit_cnt(unit_cnt),
    .shift(shift), .busy(chan_busy), .end_flag(end_flag), .irq_en(irq_en)
  );

  dmac_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .busy(chan_busy), .cnt_zero(unit_cnt == '0),
    .src_addr(src_addr), .dst_addr(dst_addr), .shift(shift),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .unit_step(unit_step), .finish(finish)
  );

  assign irq = end_flag & irq_en;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int SZ_W   = 3,
  parameter int NSZ    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SZ_W-1:0]   mem_size,
  input logic              irq,
  input logic              chan_busy,
  input logic              end_flag,
  input logic [CNT_W-1:0]  unit_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ctl_wr, cnt_wr, wr_grant;
  assign ctl_wr   = reg_we && (reg_addr[3:2] == 2'd3);
  assign cnt_wr   = reg_we && (reg_addr[3:2] == 2'd2);
  assign wr_grant = mem_req && mem_we && mem_gnt;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we)))); // R5

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_gnt) |=> (!mem_req || mem_we)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_grant |=> (($past(unit_cnt) - unit_cnt) == ONE)); // R6

  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(end_flag) |-> (unit_cnt == '0)); // R7

  AST_SIZE_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (32'(mem_size) < NSZ)); // R3

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !ctl_wr) |=> irq); // R10

  AST_BUSY_COUNT_LOCK: assert property (@(posedge clk) disable iff (rst)
    (chan_busy && cnt_wr && !wr_grant) |=> $stable(unit_cnt)); // R4
endmodule

bind dma_chan_engine dmac_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SZ_W(dmac_pkg::SZ_W), .NSZ(NSZ)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_size(mem_size), .irq(irq),
  .chan_busy(chan_busy), .end_flag(end_flag), .unit_cnt(unit_cnt)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  mem_size;
  logic        mem_gnt = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h5a5a_0000;
  endfunction
  assign mem_rdata = memfn(mem_addr);

  dma_chan_engine u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct packed { logic we; logic [3:0] a; logic [31:0] d; } op_t;
  op_t opq[$];
  int ph = 0;
  logic [31:0] m_src = 0, m_dst = 0, m_cnt = 0, m_buf = 0, m_rd = 0;
  logic m_en = 0, m_end = 0, m_ie = 0, m_si = 1, m_di = 1;
  logic [2:0] m_szi = 3'd2;
  int gmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int req_cycles = 0;
  int cyc = 0;
  bit started = 0;

  function automatic int m_shift();
    return (m_szi < 3) ? int'(m_szi) : 0;
  endfunction
  function automatic logic [31:0] m_mask(input int sh);
    return (sh == 0) ? 32'hFF : (sh == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] m_ctl();
    return {22'b0, m_di, m_si, 1'b0, m_szi, 1'b0, m_ie, m_end, m_en};
  endfunction

  always @(negedge clk) begin
    if (started) begin
      bit busy, req, g, cw, step, rl, fin;
      int sh, nph;
      logic [31:0] rdn;
      op_t op;
      cyc++;
      if (cyc > 100000) begin
        chk("watchdog expired", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      busy = m_en & ~m_end;
      req  = (ph != 0) && busy;
      sh   = m_shift();
      chk("R5 mem_req", {31'b0, mem_req}, {31'b0, req});
      if (req) begin
        req_cycles++;
        chk("R5 mem_we", {31'b0, mem_we}, (ph == 2) ? 32'd1 : 32'd0);
        chk("R6 mem_addr", mem_addr, (ph == 2) ? m_dst : m_src);
        chk("R3 mem_size", {29'b0, mem_size}, sh);
        if (ph == 2) chk("R5 mem_wdata", mem_wdata, m_buf);
      end
      chk("R10 irq", {31'b0, irq}, {31'b0, m_end & m_ie});
      chk("R1 reg_rdata", reg_rdata, m_rd);

      if (opq.size() > 0) begin
        op = opq.pop_front();
        reg_we = op.we; reg_addr = op.a; reg_wdata = op.d;
      end else begin
        reg_we = 1'b0;
      end
      case (gmode)
        0: g = 1'b1;
        1: g = 1'b0;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          g = lfsr[0];
        end
      endcase
      mem_gnt = g;

      case (reg_addr[3:2])
        2'd0: rdn = m_src;
        2'd1: rdn = m_dst;
        2'd2: rdn = m_cnt;
        default: rdn = m_ctl();
      endcase
      cw   = reg_we && (reg_addr[1:0] == 2'b00) && (reg_addr[3:2] == 2'd3);
      step = req && (ph == 2) && g;
      rl   = req && (ph == 1) && g;
      fin  = (ph == 0) && busy && (m_cnt == 0) && !cw;
      if (ph == 0) nph = (busy && m_cnt != 0) ? 1 : 0;
      else if (ph == 1) nph = !busy ? 0 : (g ? 2 : 1);
      else nph = (!busy || g) ? 0 : 2;
      if (rl) m_buf = memfn(m_src) & m_mask(sh);
      if (step) begin
        if (m_si) m_src = m_src + (32'd1 << sh);
        if (m_di) m_dst = m_dst + (32'd1 << sh);
        m_cnt = (m_cnt - 1) & 32'h00FF_FFFF;
      end
      if (reg_we && reg_addr[1:0] == 2'b00 && !busy) begin
        case (reg_addr[3:2])
          2'd0: m_src = reg_wdata;
          2'd1: m_dst = reg_wdata;
          2'd2: m_cnt = reg_wdata & 32'h00FF_FFFF;
          default: ;
        endcase
      end
      if (cw) begin
        m_en = reg_wdata[0];
        m_ie = reg_wdata[2];
        if (!reg_wdata[1]) m_end = 1'b0;
        if (!busy) begin
          m_szi = reg_wdata[6:4];
          m_si  = reg_wdata[8];
          m_di  = reg_wdata[9];
        end
      end else if (fin) begin
        m_end = 1'b1;
      end
      ph = nph;
      m_rd = rdn;
    end
  end

  task automatic drain();
    @(posedge clk);
    while (opq.size() != 0) @(posedge clk);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    opq.push_back('{we: 1'b1, a: a, d: d});
    drain();
    #1;
  endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    opq.push_back('{we: 1'b0, a: a, d: 32'h0});
    drain();
    #1;
    v = reg_rdata;
  endtask
  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask
  task automatic wait_end();
    for (int i = 0; i < 5000 && !m_end; i++) @(posedge clk);
    @(posedge clk);
    #1;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] c, s, d;
    int rc;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    started = 1;

    // reset state
    chk("R2 irq after reset", {31'b0, irq}, 32'd0);
    chk("R2 mem_req after reset", {31'b0, mem_req}, 32'd0);
    rdchk("R2 src reset", 4'h0, 32'h0);
    rdchk("R2 dst reset", 4'h4, 32'h0);
    rdchk("R2 count reset", 4'h8, 32'h0);
    rdchk("R2 ctl reset", 4'hC, 32'h320);

    // register access
    wr(4'h0, 32'h100);
    wr(4'h4, 32'h200);
    wr(4'h8, 32'hFF00_0005);
    rdchk("R11 count truncated", 4'h8, 32'h5);
    wr(4'h1, 32'h77);
    rdchk("R1 misaligned write ignored", 4'h0, 32'h100);
    rdchk("R1 dst readback", 4'h4, 32'h200);

    // 4-byte units, continuous grant
    wr(4'hC, 32'h325);
    wait_end();
    chk("R10 irq at end", {31'b0, irq}, 32'd1);
    rdchk("R6 count drained", 4'h8, 32'h0);
    rdchk("R6 src end", 4'h0, 32'h114);
    rdchk("R6 dst end", 4'h4, 32'h214);
    rdchk("R7 end flag set", 4'hC, 32'h327);

    // end-flag write semantics
    wr(4'hC, 32'h326);
    rdchk("R8 writing 1 keeps end flag", 4'hC, 32'h326);
    chk("R10 irq held", {31'b0, irq}, 32'd1);
    wr(4'hC, 32'h320);
    rdchk("R8 writing 0 clears end flag", 4'hC, 32'h320);
    chk("R10 irq cleared", {31'b0, irq}, 32'd0);
    wr(4'hC, 32'h322);
    rdchk("R8 writing 1 does not set end flag", 4'hC, 32'h320);

    // 2-byte units, fixed source, irregular grant
    gmode = 2;
    wr(4'h0, 32'h1000);
    wr(4'h4, 32'h2001);
    wr(4'h8, 32'd6);
    wr(4'hC, 32'h215);
    wait_end();
    rdchk("R6 fixed source", 4'h0, 32'h1000);
    rdchk("R6 dst after 2-byte units", 4'h4, 32'h200D);
    wr(4'hC, 32'h0);

    // out-of-range size index -> 1 byte
    wr(4'h0, 32'h3000);
    wr(4'h4, 32'h4000);
    wr(4'h8, 32'd3);
    wr(4'hC, 32'h355);
    wait_end();
    rdchk("R3 index 5 acts as 1 byte src", 4'h0, 32'h3003);
    rdchk("R3 index 5 acts as 1 byte dst", 4'h4, 32'h4003);
    wr(4'hC, 32'h320);

    // busy lockout with a stalled grant
    gmode = 1;
    wr(4'h0, 32'h5000);
    wr(4'h4, 32'h6000);
    wr(4'h8, 32'd50);
    wr(4'hC, 32'h325);
    wr(4'h0, 32'hDEAD);
    wr(4'h4, 32'hBEEF);
    wr(4'h8, 32'd7);
    wr(4'hC, 32'h015);
    rdchk("R4 src locked", 4'h0, 32'h5000);
    rdchk("R4 dst locked", 4'h4, 32'h6000);
    rdchk("R4 count locked", 4'h8, 32'd50);
    rdchk("R4 size and inc locked", 4'hC, 32'h325);

    // halt while stalled
    wr(4'hC, 32'h320);
    idle(2);
    rc = req_cycles;
    idle(10);
    chk("R9 no request after halt", req_cycles, rc);
    rdchk("R9 count kept", 4'h8, 32'd50);

    // partial progress then resume
    gmode = 2;
    wr(4'hC, 32'h325);
    idle(30);
    wr(4'hC, 32'h320);
    idle(3);
    rd(4'h8, c);
    rd(4'h0, s);
    rd(4'h4, d);
    chk("R9 progress made", {31'b0, (c < 50) && (c > 0)}, 32'd1);
    chk("R9 src matches remaining", s - 32'h5000, (50 - c) * 4);
    chk("R9 dst matches remaining", d - 32'h6000, (50 - c) * 4);
    gmode = 0;
    wr(4'hC, 32'h325);
    wait_end();
    rdchk("R9 resumed src end", 4'h0, 32'h50C8);
    rdchk("R9 resumed dst end", 4'h4, 32'h60C8);
    wr(4'hC, 32'h320);

    // zero count start
    wr(4'h8, 32'd0);
    rc = req_cycles;
    wr(4'hC, 32'h325);
    wait_end();
    chk("R7 zero count makes no request", req_cycles, rc);
    rdchk("R7 zero count ends", 4'hC, 32'h327);
    wr(4'hC, 32'h320);
    idle(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule